// File: doc/BRIEF.md
# Half-Width Pulse Position Modulator

This block turns a stream of small data words into a pulse position modulated bit stream. Time is cut into frames. Each frame holds a fixed number of slots, and each slot holds a fixed number of clock ticks. For every accepted word, exactly one pulse goes out, and the slot it lands in encodes the word value. The pulse is high for only the first half of its slot. Every slot period therefore holds a low stretch, and a receiver can lock its slot clock onto that regular gap.

Words enter over a valid/ready handshake that opens for one cycle near the end of each frame. A word taken in that cycle is sent in the frame that follows. When no word is offered at that moment, the next frame carries no pulse and a flag marks it as idle. Two timing outputs let neighbouring logic stay aligned: a frame-start marker and a per-slot strobe. The slot count (a power of two, default 4) and the ticks per slot (even, at least 2) are parameters.

Top module: `halfpulse_ppm_tx`

## Requirements
- R1: `frame_start` is high for exactly one cycle in every SLOTS*TICKS cycles. It is first high in the cycle that follows the first rising clock edge with `rst` low.
- R2: `slot_strobe` is high for one cycle in every TICKS cycles, and it is high whenever `frame_start` is high.
- R3: A pulse on `pulse_out` rises in the same cycle as a `slot_strobe` and stays high for exactly TICKS/2 consecutive cycles. It is low for the rest of that slot.
- R4: A word of value k, counted from 0, puts the pulse in slot k of its frame. Slot 0 begins at `frame_start`, and slot k begins k*TICKS cycles later. A frame carrying a word has exactly one pulse.
- R5: `in_ready` is high for exactly one cycle per frame, two cycles before `frame_start`. A word presented with `in_valid` high in that cycle is transmitted in the frame that starts two cycles later.
- R6: `in_valid` and `in_data` in any cycle where `in_ready` is low have no effect on `pulse_out` or `idle_flag`.
- R7: If `in_valid` is low while `in_ready` is high, the next frame has `pulse_out` low throughout and `idle_flag` high throughout. In frames carrying a word, `idle_flag` is low.
- R8: While `rst` is high, every output is low. After `rst` is released, the first frame is idle, and the whole timing sequence restarts from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | log2(SLOTS) | Word that selects the pulse slot |
| in_valid | input | 1 | A word is offered on `in_data` |
| in_ready | output | 1 | Word accepted this cycle if `in_valid` is high |
| pulse_out | output | 1 | Modulated half-width pulse stream |
| frame_start | output | 1 | One-cycle marker at the first tick of slot 0 |
| slot_strobe | output | 1 | One-cycle marker at the first tick of every slot |
| idle_flag | output | 1 | High for the whole of a frame sent without a word |

## Verification
Every output is registered from the tick and slot counters. Each output therefore shows the position the counters held one cycle earlier. `in_ready` leads `frame_start` by two cycles. A word of value k accepted at a clock edge first shows as a `pulse_out` high k*TICKS+1 cycles after that edge.

The bench numbers the rising edges since reset release. From that edge number alone it works out the frame, slot and tick that the outputs must show. It keeps a per-frame plan of what it offered at each acceptance cycle, and it compares all five outputs against that plan in the middle of every cycle. Cycles that it uses to offer junk words outside the acceptance cycle are checked in the same way, so any effect of a junk word would show up at the outputs.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  // Default frame geometry.
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_TICKS = 8;

  // Registered line outputs of the modulator.
  typedef struct packed {
    logic pulse;
    logic frame;
    logic strobe;
    logic idle;
  } ppm_line_t;

endpackage

// File: rtl/ppm_slot_timer.sv
module ppm_slot_timer #(
  parameter int unsigned SLOTS  = 4,
  parameter int unsigned TICKS  = 8,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic [TICK_W-1:0] tick_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_end_o
);

  localparam logic [TICK_W-1:0] LAST_T = TICK_W'(TICKS - 1);
  localparam logic [TICK_W-1:0] PRE_T  = TICK_W'(TICKS - 2);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(SLOTS - 1);

  logic [TICK_W-1:0] tick_q;
  logic [SLOT_W-1:0] slot_q;
  logic              end_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      slot_q <= '0;
      end_q  <= 1'b0;
    end else begin
      if (tick_q == LAST_T) begin
        tick_q <= '0;
        slot_q <= (slot_q == LAST_S) ? '0 : slot_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
      // High in the cycle when the counters sit on the last tick of the frame
      end_q <= (slot_q == LAST_S) && (tick_q == PRE_T);
    end
  end

  assign tick_o      = tick_q;
  assign slot_o      = slot_q;
  assign frame_end_o = end_q;

  // R1: tick counter never leaves its range
  p_tick_range_r1: assert property (@(posedge clk) disable iff (rst)
    tick_q <= LAST_T);

  // R5: the acceptance window is a single cycle
  p_ready_single_r5: assert property (@(posedge clk) disable iff (rst)
    end_q |=> !end_q);

  // R5: the acceptance window coincides with the last tick of the frame
  p_ready_at_end_r5: assert property (@(posedge clk) disable iff (rst)
    end_q |-> (tick_q == LAST_T && slot_q == LAST_S));

endmodule

// File: rtl/ppm_word_latch.sv
module ppm_word_latch #(
  parameter int unsigned SLOT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_i,
  input  logic              valid_i,
  input  logic [SLOT_W-1:0] data_i,
  output logic [SLOT_W-1:0] sel_o,
  output logic              active_o
);

  logic [SLOT_W-1:0] sel_q;
  logic              active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= '0;
      active_q <= 1'b0;
    end else if (take_i) begin
      active_q <= valid_i;
      if (valid_i) sel_q <= data_i;
    end
  end

  assign sel_o    = sel_q;
  assign active_o = active_q;

  // R6: outside the acceptance window the frame content cannot change
  p_hold_word_r6: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(sel_q) && $stable(active_q)));

  // R7: an empty acceptance window leads to an idle frame
  p_empty_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (take_i && !valid_i) |=> !active_q);

endmodule

// File: rtl/ppm_pulse_shaper.sv
module ppm_pulse_shaper
  import ppm_pkg::*;
#(
  parameter int unsigned TICKS  = 8,
  parameter int unsigned SLOT_W = 2,
  parameter int unsigned TICK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TICK_W-1:0] tick_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] sel_i,
  input  logic              active_i,
  output ppm_line_t         line_o
);

  localparam logic [TICK_W-1:0] HALF_T = TICK_W'(TICKS / 2);

  ppm_line_t line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else begin
      line_q.pulse  <= active_i && (slot_i == sel_i) && (tick_i < HALF_T);
      line_q.frame  <= (slot_i == '0) && (tick_i == '0);
      line_q.strobe <= (tick_i == '0);
      line_q.idle   <= !active_i;
    end
  end

  assign line_o = line_q;

  // Length of the current high run on the pulse line, for the width check
  logic [TICK_W:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)              run_q <= '0;
    else if (line_q.pulse) run_q <= run_q + 1'b1;
    else                  run_q <= '0;
  end

  // R3: a pulse begins on a slot boundary
  p_rise_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(line_q.pulse) |-> line_q.strobe);

  // R3: a pulse lasts exactly half a slot
  p_half_width_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(line_q.pulse) |-> (run_q == {1'b0, HALF_T}));

  // R2: frame marker only on a slot boundary
  p_frame_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    line_q.frame |-> line_q.strobe);

  // R7: idle frames stay dark
  p_idle_dark_r7: assert property (@(posedge clk) disable iff (rst)
    line_q.idle |-> !line_q.pulse);

endmodule

// File: rtl/halfpulse_ppm_tx.sv
module halfpulse_ppm_tx
  import ppm_pkg::*;
#(
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned TICKS  = DEF_TICKS,
  parameter int unsigned WORD_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              pulse_out,
  output logic              frame_start,
  output logic              slot_strobe,
  output logic              idle_flag
);

  localparam int unsigned TICK_W = $clog2(TICKS);

  logic [TICK_W-1:0] tick;
  logic [WORD_W-1:0] slot;
  logic              frame_end;
  logic [WORD_W-1:0] sel;
  logic              active;
  ppm_line_t         line;

  ppm_slot_timer #(
    .SLOTS (SLOTS),
    .TICKS (TICKS),
    .SLOT_W(WORD_W),
    .TICK_W(TICK_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick_o     (tick),
    .slot_o     (slot),
    .frame_end_o(frame_end)
  );

  ppm_word_latch #(
    .SLOT_W(WORD_W)
  ) u_latch (
    .clk     (clk),
    .rst     (rst),
    .take_i  (frame_end),
    .valid_i (in_valid),
    .data_i  (in_data),
    .sel_o   (sel),
    .active_o(active)
  );

  ppm_pulse_shaper #(
    .TICKS (TICKS),
    .SLOT_W(WORD_W),
    .TICK_W(TICK_W)
  ) u_shaper (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .slot_i  (slot),
    .sel_i   (sel),
    .active_i(active),
    .line_o  (line)
  );

  assign in_ready    = frame_end;
  assign pulse_out   = line.pulse;
  assign frame_start = line.frame;
  assign slot_strobe = line.strobe;
  assign idle_flag   = line.idle;

  // R5: frame start follows the acceptance window by two cycles
  p_ready_lead_r5: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> ##1 frame_start);

endmodule

// File: tb/halfpulse_ppm_tx_bench.sv
module halfpulse_ppm_tx_bench;

  localparam int SLOTS  = 4;
  localparam int TICKS  = 8;
  localparam int WORD_W = 2;
  localparam int LT     = SLOTS * TICKS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [WORD_W-1:0] in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready, pulse_out, frame_start, slot_strobe, idle_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  halfpulse_ppm_tx #(.SLOTS(SLOTS), .TICKS(TICKS)) u_halfpulse_ppm_tx (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .pulse_out(pulse_out), .frame_start(frame_start),
    .slot_strobe(slot_strobe), .idle_flag(idle_flag)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Frame plan: phase 0 is the main sweep, phase 1 follows the second reset
  function automatic bit plan_act(input int ph, input int f);
    if (f == 0) return 1'b0;
    if (ph == 0) return (f % 3) != 0;
    return f == 1;
  endfunction

  function automatic int plan_word(input int ph, input int f);
    if (ph == 0) return f % SLOTS;
    return SLOTS - 1;
  endfunction

  task automatic check_reset_state();
    chk("R8 pulse_out", pulse_out, 1'b0);
    chk("R8 frame_start", frame_start, 1'b0);
    chk("R8 slot_strobe", slot_strobe, 1'b0);
    chk("R8 idle_flag", idle_flag, 1'b0);
    chk("R8 in_ready", in_ready, 1'b0);
  endtask

  task automatic run_phase(input int ph, input int frames);
    int e = 0;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    while (e < frames * LT) begin
      // Set inputs for the cycle whose counters equal e
      if (e % LT == LT - 1) begin
        in_valid = plan_act(ph, (e + 1) / LT);
        in_data  = WORD_W'(plan_word(ph, (e + 1) / LT));
      end else begin
        // R6: junk offers outside the window
        in_valid = (e % 3) == 0;
        in_data  = WORD_W'(e + 1);
      end
      @(posedge clk);
      e++;
      @(negedge clk);
      begin
        int p  = e - 1;
        int f  = p / LT;
        int s  = (p % LT) / TICKS;
        int t  = p % TICKS;
        bit ac = plan_act(ph, f);
        int w  = plan_word(ph, f);
        chk("R1 frame_start", frame_start, (p % LT) == 0);
        chk("R2 slot_strobe", slot_strobe, t == 0);
        chk("R3/R4/R6 pulse_out", pulse_out, ac && (s == w) && (t < TICKS / 2));
        chk("R7 idle_flag", idle_flag, !ac);
        chk("R5 in_ready", in_ready, (e % LT) == LT - 1);
      end
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_phase(0, 13);
    // R8: reset in the middle of operation
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    run_phase(1, 3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule